// File: doc/BRIEF.md
# Column-Sum Unsigned Multiplier

This block multiplies two unsigned 4-bit operands and returns their 8-bit product. It is built in three stages. First, a grid of two-input AND gates forms every single-bit product. Second, for each output weight, the bit products whose index pair adds up to that weight are counted into a small multi-bit column sum. No carry passes between columns at this stage.

Third, each column sum is split into bits. Every bit is moved to its true weight, so the low bit stays put, the middle bit moves one place up and the top bit moves two places up. This gives three sparse 8-bit rows. One full-adder row reduces the three rows to two vectors. An 8-bit carry-lookahead adder then adds the two vectors. Inside that adder, two 4-bit groups share a group-level lookahead carry.

A parameter chooses what drives the product. The product can come straight from the adder, or it can pass through one output register. The register has a synchronous active-high reset that clears it to zero.

Top module: `colsum_mult`

## Requirements
- R1: For every unsigned operand pair, the product equals a*b as an 8-bit value. This covers all 256 pairs.
- R2: Product bit 0 equals the AND of operand bit 0 of `a` and operand bit 0 of `b`.
- R3: Single-bit operands a = 2^i and b = 2^j give the product 2^(i+j), for every i and j from 0 to 3.
- R4: With both operands at 15, the product is 225. The weight-3 column then holds its largest value, 4, and the adder produces no carry beyond bit 7.
- R5: The following fixed vectors give the stated products:
  - 1101 × 1001 gives 1110101 (117);
  - 1010 × 1010 gives 1100100 (100);
  - 1100 × 1100 gives 10010000 (144).
- R6: With the default registered output, `prod` shows the product of the operands sampled at a rising clock edge. It holds that value from that edge until the next edge.
- R7: While `rst` is high at a rising edge, `prod` becomes 0 after that edge, whatever the operands are. Reset takes priority over capturing a new product in the same cycle.
- R8: If either operand is zero, the product is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | 4 | Unsigned multiplicand |
| b | input | 4 | Unsigned multiplier |
| prod | output | 8 | Unsigned product |

## Verification
Two actions can fall on the same clock edge: capturing a new product into the output register, and clearing that register by reset. The bench provokes this by raising `rst` in the same cycle that it drives the largest operand pair, 15 × 15. The register would otherwise load 225 on that edge, so a zero output after the edge shows that reset won. The bench also checks that the first product captured after reset is released is correct.

// File: rtl/colsum_mult.sv
module colsum_mult #(
  parameter int OPW     = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  output logic [2*OPW-1:0] prod
);
  localparam int PW  = 2 * OPW;
  localparam int NC  = 2 * OPW - 1;
  localparam int CW  = $clog2(OPW + 1);
  localparam int GW  = 4;
  localparam int NG  = (PW + GW - 1) / GW;

  logic [OPW-1:0] pp [OPW];
  logic [CW-1:0]  col [NC];
  logic [PW-1:0]  row0, row1, row2;
  logic [PW-1:0]  sv, cv, maj;
  logic [PW-1:0]  g, p;
  logic [PW:0]    cy;
  logic [PW-1:0]  sum_w;
  logic           cout_w;

  for (genvar i = 0; i < OPW; i++) begin : g_and_row
    for (genvar j = 0; j < OPW; j++) begin : g_and_bit
      assign pp[i][j] = a[i] & b[j];
    end
  end

  always_comb begin
    for (int k = 0; k < NC; k++) begin
      col[k] = '0;
      for (int i = 0; i < OPW; i++)
        for (int j = 0; j < OPW; j++)
          if (i + j == k) col[k] = col[k] + CW'(pp[i][j]);
    end
  end

  always_comb begin
    row0 = '0;
    row1 = '0;
    row2 = '0;
    for (int k = 0; k < NC; k++) begin
      row0[k] = col[k][0];
      if (CW > 1 && k + 1 < PW) row1[k+1] = col[k][1 % CW];
      if (CW > 2 && k + 2 < PW) row2[k+2] = col[k][2 % CW];
    end
  end

  assign sv  = row0 ^ row1 ^ row2;
  assign maj = (row0 & row1) | (row0 & row2) | (row1 & row2);
  assign cv  = {maj[PW-2:0], 1'b0};

  assign g = sv & cv;
  assign p = sv ^ cv;

  always_comb begin
    logic [NG:0]   gc;
    logic [NG-1:0] gg, gp;
    logic          t, acc;
    int            base, top;
    for (int q = 0; q < NG; q++) begin
      base = q * GW;
      top  = (base + GW > PW) ? PW : base + GW;
      acc  = 1'b0;
      t    = 1'b1;
      for (int j = base; j < top; j++) begin
        acc = g[j] | (p[j] & acc);
        t   = t & p[j];
      end
      gg[q] = acc;
      gp[q] = t;
    end
    gc[0] = 1'b0;
    for (int q = 0; q < NG; q++) gc[q+1] = gg[q] | (gp[q] & gc[q]);
    cy = '0;
    for (int q = 0; q < NG; q++) begin
      base = q * GW;
      top  = (base + GW > PW) ? PW : base + GW;
      for (int i = base; i <= top; i++) begin
        acc = 1'b0;
        for (int j = base; j < i; j++) begin
          t = g[j];
          for (int m = j + 1; m < i; m++) t = t & p[m];
          acc = acc | t;
        end
        t = gc[q];
        for (int m = base; m < i; m++) t = t & p[m];
        if (i == top) cy[i] = gc[q+1];
        else          cy[i] = acc | t;
      end
    end
  end

  assign sum_w  = p ^ cy[PW-1:0];
  assign cout_w = cy[PW];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) prod <= '0;
      else     prod <= sum_w;
    end
  end else begin : g_comb
    assign prod = sum_w;
  end
endmodule

module colsum_mult_chk #(
  parameter int OPW     = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [OPW-1:0]   a,
  input logic [OPW-1:0]   b,
  input logic [2*OPW-1:0] prod,
  input logic [2*OPW-1:0] sum_w,
  input logic [2*OPW-1:0] sv,
  input logic [2*OPW-1:0] cv,
  input logic             cout_w
);
  localparam int PW = 2 * OPW;
  logic [PW-1:0] ref_p;
  logic [PW:0]   csa_total;
  assign ref_p     = PW'(a) * PW'(b);
  assign csa_total = {1'b0, sv} + {1'b0, cv};

  assert_adder_product_R1: assert property (@(posedge clk) disable iff (rst)
    sum_w == ref_p);
  assert_csa_rows_R1: assert property (@(posedge clk) disable iff (rst)
    csa_total == {1'b0, ref_p});
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    !cout_w);

  if (REG_OUT) begin : g_reg_chk
    assert_reg_latency_R6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> prod == $past(ref_p));
    assert_bit0_R2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> prod[0] == ($past(a[0]) & $past(b[0])));
    assert_reset_clear_R7: assert property (@(posedge clk)
      rst |=> prod == '0);
  end else begin : g_comb_chk
    assert_comb_out_R1: assert property (@(posedge clk) disable iff (rst)
      prod == ref_p);
    assert_bit0_R2: assert property (@(posedge clk) disable iff (rst)
      prod[0] == (a[0] & b[0]));
  end
endmodule

bind colsum_mult colsum_mult_chk #(.OPW(OPW), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .prod(prod),
  .sum_w(sum_w), .sv(sv), .cv(cv), .cout_w(cout_w)
);

// File: tb/colsum_mult_bench.sv
module colsum_mult_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a = '0;
  logic [3:0] b = '0;
  logic [7:0] prod;

  int tests = 0;
  int fails = 0;
  int     exp_q [$];
  int     b0_q  [$];
  string  tag_q [$];

  colsum_mult u_colsum_mult (.clk(clk), .rst(rst), .a(a), .b(b), .prod(prod));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_front();
    int e, bz;
    string t;
    if (exp_q.size() > 0) begin
      e  = exp_q.pop_front();
      bz = b0_q.pop_front();
      t  = tag_q.pop_front();
      check(t, int'(prod), e);
      check("R2", int'(prod[0]), bz);
    end
  endtask

  task automatic step(input int x, input int y, input string tag);
    @(negedge clk);
    compare_front();
    a = 4'(x);
    b = 4'(y);
    exp_q.push_back(x * y);
    b0_q.push_back((x & 1) & (y & 1));
    tag_q.push_back(tag);
  endtask

  task automatic flush();
    @(negedge clk);
    compare_front();
  endtask

  initial begin
    a = 4'd5;
    b = 4'd3;
    @(negedge clk);
    @(negedge clk);
    check("R7 reset state", int'(prod), 0);
    rst = 1'b0;

    step(13, 9, "R5 13x9");
    step(10, 10, "R5 10x10");
    step(12, 12, "R5 12x12");
    step(0, 15, "R8 zero a");
    step(9, 0, "R8 zero b");
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        step(1 << i, 1 << j, "R3 single bits");
    step(15, 15, "R4 max");
    step(6, 7, "R6 latency");
    step(7, 6, "R6 latency");
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        step(x, y, "R1 sweep");
    flush();

    @(negedge clk);
    rst = 1'b1;
    a = 4'd15;
    b = 4'd15;
    @(negedge clk);
    check("R7 reset beats capture", int'(prod), 0);
    a = 4'd7;
    b = 4'd9;
    @(negedge clk);
    check("R7 reset held", int'(prod), 0);
    rst = 1'b0;
    step(3, 5, "R6 first after reset");
    step(11, 14, "R1 after reset");
    flush();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule